// File: doc/BRIEF.md
# Bit-Addressable SRAM Slave Controller

This block is the bus slave in front of a 32-bit-wide on-chip data SRAM. Requests arrive on an AHB-lite style pipelined interface: an address phase followed by a data phase. Two address windows are decoded. The direct window gives byte, halfword and word access to the memory. The bit window gives every bit of the memory its own word-aligned address. A bit-window read returns the chosen bit on its own. A bit-window write rewrites the containing word atomically, so that only that one bit changes.

The address window is sized for a fixed maximum. The memory actually fitted may be smaller than that window. Any access that lands in the window but above the fitted size is answered with the two-cycle bus error response, and the memory is not touched. A selected access that lands in neither window is refused in the same way. The memory inside the block is a synchronous single-port array built from byte lanes. Both the memory size and the window size are parameters.

Top module: `bbsram_ctrl`

## Requirements
- R1: After reset with no transfer in progress, hreadyout is 1 and hresp is 0.
- R2: A direct-window word write completes with no wait state. A direct-window read completes with exactly one wait state and returns the stored word.
- R3: A direct-window write with hsize 0 updates only byte lane haddr[1:0]. With hsize 1 it updates lanes 1:0 when haddr[1] is 0 and lanes 3:2 otherwise. With hsize 2 it updates all four lanes. Lane n of hwdata is bits 8n+7:8n.
- R4: For a bit-window offset A (haddr minus the bit-window base), the bit addressed is bit A[6:2] of memory word A/128, which is byte A/32 of the direct window. A read there returns that bit in hrdata[0] with hrdata[31:1] zero, after one wait state.
- R5: A bit-window write sets the addressed bit to hwdata[0] and leaves the other 31 bits of the word unchanged. hwdata[31:1] is ignored. The write takes one wait state.
- R6: A direct-window access whose byte offset is at or above the fitted size gives the error response: hreadyout 0 with hresp 1 in the first data-phase cycle, then hreadyout 1 with hresp 1.
- R7: An erroring write leaves every memory word unchanged.
- R8: A bit-window access whose word lies at or above the fitted size gives the R6 error response and performs no memory access.
- R9: A selected transfer whose address lies outside both windows gives the R6 error response.
- R10: The read-modify-write is atomic. A transfer pipelined directly behind a bit-window write is held off until the write-back has happened, and a read of the same word then returns the updated value.
- R11: A cycle with hsel low, or with htrans IDLE or BUSY, starts no transfer. hreadyout stays 1, hresp stays 0 and the memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select for the address phase |
| haddr | input | 32 | Byte address of the address phase |
| htrans | input | 2 | Transfer type; NONSEQ (10) and SEQ (11) start a transfer |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word (direct window only) |
| hwdata | input | 32 | Write data, valid in the data phase |
| hrdata | output | 32 | Read data, valid when hreadyout is 1 at the end of a read |
| hreadyout | output | 1 | Data phase completes in this cycle |
| hresp | output | 1 | 1 signals an error response |

## Verification
Assertions check the following on every cycle. An error response always comes as a stalled cycle followed by a completing one, and the memory is never enabled while an error is reported. Each bit-window read of the memory is followed at once by a full-word write-back to the same word. Memory reads happen only in stalled cycles. A ready cycle with no accepted transfer leaves the slave idle. The bench scenarios cover what needs a reference image of the memory: the lane placement of byte and halfword writes, the mapping from bit address to word and bit, the preservation of the neighbouring bits, the fact that out-of-range writes do not wrap onto fitted words, and the ordering of a read pipelined behind a read-modify-write.

// File: rtl/bbsram_pkg.sv
package bbsram_pkg;

   // Decoded class of an address-phase request
   typedef enum logic [1:0] {
      ACC_WORD  = 2'd0,
      ACC_BIT   = 2'd1,
      ACC_FAULT = 2'd2
   } acc_kind_e;

   // Data-phase sequencer states
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_ISSUE = 3'd1,
      ST_RD_DATA  = 3'd2,
      ST_WR       = 3'd3,
      ST_RMW_RD   = 3'd4,
      ST_RMW_WR   = 3'd5,
      ST_ERR1     = 3'd6,
      ST_ERR2     = 3'd7
   } seq_state_e;

   // Byte-lane enables of a 32-bit bus for a given transfer size and low address
   function automatic logic [3:0] lane_enables(input logic [2:0] size, input logic [1:0] low);
      logic [3:0] en;
      case (size)
         3'd0:    en = 4'b0001 << low;
         3'd1:    en = low[1] ? 4'b1100 : 4'b0011;
         default: en = 4'b1111;
      endcase
      return en;
   endfunction

endpackage

// File: rtl/bbsram_decode.sv
module bbsram_decode
   import bbsram_pkg::*;
#(
   parameter int unsigned WIN_BYTES   = 32768,
   parameter int unsigned FIT_BYTES   = 16384,
   parameter logic [31:0] DIRECT_BASE = 32'h2000_0000,
   parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
   localparam int unsigned WIN_AW     = $clog2(WIN_BYTES),
   localparam int unsigned ALIAS_AW   = WIN_AW + 5,
   localparam int unsigned FIT_AW     = $clog2(FIT_BYTES),
   localparam int unsigned WORD_AW    = FIT_AW - 2
) (
   input  logic [31:0]        addr_i,
   input  logic [2:0]         size_i,
   output acc_kind_e          kind_o,
   output logic [WORD_AW-1:0] word_o,
   output logic [4:0]         bit_o,
   output logic [3:0]         lanes_o
);

   logic in_direct;
   logic in_alias;
   logic direct_fit;
   logic alias_fit;

   assign in_direct = (addr_i[31:WIN_AW]   == DIRECT_BASE[31:WIN_AW]);
   assign in_alias  = (addr_i[31:ALIAS_AW] == ALIAS_BASE[31:ALIAS_AW]);

   // Range check above the fitted size only exists when memory is smaller than the window
   generate
      if (FIT_BYTES == WIN_BYTES) begin : g_full_fit
         assign direct_fit = 1'b1;
         assign alias_fit  = 1'b1;
      end else begin : g_part_fit
         assign direct_fit = (addr_i[WIN_AW-1:FIT_AW]     == '0);
         assign alias_fit  = (addr_i[ALIAS_AW-1:FIT_AW+5] == '0);
      end
   endgenerate

   always_comb begin
      if (in_direct) begin
         kind_o  = direct_fit ? ACC_WORD : ACC_FAULT;
         word_o  = addr_i[FIT_AW-1:2];
         lanes_o = lane_enables(size_i, addr_i[1:0]);
      end else if (in_alias) begin
         kind_o  = alias_fit ? ACC_BIT : ACC_FAULT;
         word_o  = addr_i[FIT_AW+4:7];
         lanes_o = 4'b1111;
      end else begin
         kind_o  = ACC_FAULT;
         word_o  = '0;
         lanes_o = 4'b0000;
      end
   end

   // bit index within the word comes from the alias offset bits just above the word alignment
   assign bit_o = addr_i[6:2];

endmodule

// File: rtl/bbsram_mem.sv
module bbsram_mem #(
   parameter int unsigned WORDS = 4096,
   parameter int unsigned LANES = 4,
   localparam int unsigned AW   = $clog2(WORDS),
   localparam int unsigned DW   = 8 * LANES
) (
   input  logic             clk,
   input  logic             en_i,
   input  logic [LANES-1:0] we_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o
);

   logic rd_en;
   assign rd_en = en_i && (we_i == '0);

   // One byte-wide array per lane; a read captures every lane, a write touches only enabled lanes
   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         logic [7:0] store [WORDS];
         logic [7:0] q;
         always_ff @(posedge clk) begin
            if (en_i && we_i[ln]) store[addr_i] <= wdata_i[8*ln +: 8];
            if (rd_en)            q <= store[addr_i];
         end
         assign rdata_o[8*ln +: 8] = q;
      end
   endgenerate

endmodule

// File: rtl/bbsram_seq.sv
module bbsram_seq
   import bbsram_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hsel_i,
   input  logic [1:0] htrans_i,
   input  logic       hwrite_i,
   input  acc_kind_e  kind_i,
   output seq_state_e state_o,
   output logic       accept_o,
   output logic       ready_o,
   output logic       resp_o
);

   seq_state_e state_q;
   seq_state_e state_d;
   seq_state_e start_st;
   logic       active_trans;

   assign active_trans = (htrans_i == 2'b10) || (htrans_i == 2'b11);

   always_comb begin
      case (state_q)
         ST_RD_ISSUE, ST_RMW_RD, ST_ERR1: ready_o = 1'b0;
         default:                         ready_o = 1'b1;
      endcase
   end

   assign resp_o   = (state_q == ST_ERR1) || (state_q == ST_ERR2);
   assign accept_o = ready_o && hsel_i && active_trans;

   always_comb begin
      case (kind_i)
         ACC_WORD: start_st = hwrite_i ? ST_WR     : ST_RD_ISSUE;
         ACC_BIT:  start_st = hwrite_i ? ST_RMW_RD : ST_RD_ISSUE;
         default:  start_st = ST_ERR1;
      endcase
   end

   always_comb begin
      if (ready_o) begin
         state_d = accept_o ? start_st : ST_IDLE;
      end else begin
         case (state_q)
            ST_RD_ISSUE: state_d = ST_RD_DATA;
            ST_RMW_RD:   state_d = ST_RMW_WR;
            default:     state_d = ST_ERR2;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   // R11: a ready cycle without an accepted transfer leaves the slave idle and ready
   a_r11_idle_stays_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !accept_o) |=> (ready_o && !resp_o));

endmodule

// File: rtl/bbsram_ctrl.sv
module bbsram_ctrl
   import bbsram_pkg::*;
#(
   parameter int unsigned WIN_BYTES   = 32768,
   parameter int unsigned FIT_BYTES   = 16384,
   parameter logic [31:0] DIRECT_BASE = 32'h2000_0000,
   parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hsel,
   input  logic [31:0] haddr,
   input  logic [1:0]  htrans,
   input  logic        hwrite,
   input  logic [2:0]  hsize,
   input  logic [31:0] hwdata,
   output logic [31:0] hrdata,
   output logic        hreadyout,
   output logic        hresp
);

   localparam int unsigned WIN_AW  = $clog2(WIN_BYTES);
   localparam int unsigned FIT_AW  = $clog2(FIT_BYTES);
   localparam int unsigned WORD_AW = FIT_AW - 2;
   localparam int unsigned WORDS   = FIT_BYTES / 4;

   // Elaboration-time configuration checks
   initial begin : p_cfg
      assert ((1 << FIT_AW) == FIT_BYTES) else $error("FIT_BYTES must be a power of two");
      assert ((1 << WIN_AW) == WIN_BYTES) else $error("WIN_BYTES must be a power of two");
      assert (FIT_BYTES <= WIN_BYTES && FIT_BYTES >= 8) else $error("FIT_BYTES out of range");
      assert (WIN_AW + 5 <= 31) else $error("bit window exceeds address space");
      assert ((DIRECT_BASE & (WIN_BYTES - 1)) == 0) else $error("DIRECT_BASE misaligned");
      assert ((ALIAS_BASE & (32 * WIN_BYTES - 1)) == 0) else $error("ALIAS_BASE misaligned");
   end

   acc_kind_e          dec_kind;
   logic [WORD_AW-1:0] dec_word;
   logic [4:0]         dec_bit;
   logic [3:0]         dec_lanes;

   seq_state_e         state;
   logic               accept;

   logic [WORD_AW-1:0] dp_word;
   logic [4:0]         dp_bit;
   logic [3:0]         dp_lanes;
   logic               dp_alias;
   logic               dp_bitval;

   logic               mem_en;
   logic [3:0]         mem_we;
   logic [31:0]        mem_wdata;
   logic [31:0]        mem_q;
   logic [31:0]        merged;

   bbsram_decode #(
      .WIN_BYTES   (WIN_BYTES),
      .FIT_BYTES   (FIT_BYTES),
      .DIRECT_BASE (DIRECT_BASE),
      .ALIAS_BASE  (ALIAS_BASE)
   ) u_decode (
      .addr_i  (haddr),
      .size_i  (hsize),
      .kind_o  (dec_kind),
      .word_o  (dec_word),
      .bit_o   (dec_bit),
      .lanes_o (dec_lanes)
   );

   bbsram_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hsel_i   (hsel),
      .htrans_i (htrans),
      .hwrite_i (hwrite),
      .kind_i   (dec_kind),
      .state_o  (state),
      .accept_o (accept),
      .ready_o  (hreadyout),
      .resp_o   (hresp)
   );

   // Address-phase capture into data-phase registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_word   <= '0;
         dp_bit    <= '0;
         dp_lanes  <= '0;
         dp_alias  <= 1'b0;
         dp_bitval <= 1'b0;
      end else begin
         if (accept) begin
            dp_word  <= dec_word;
            dp_bit   <= dec_bit;
            dp_lanes <= dec_lanes;
            dp_alias <= (dec_kind == ACC_BIT);
         end
         if (state == ST_RMW_RD) dp_bitval <= hwdata[0];
      end
   end

   // Single-bit merge for the write-back half of the read-modify-write
   always_comb begin
      merged         = mem_q;
      merged[dp_bit] = dp_bitval;
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 4'b0000;
      mem_wdata = hwdata;
      case (state)
         ST_RD_ISSUE, ST_RMW_RD: mem_en = 1'b1;
         ST_WR: begin
            mem_en = 1'b1;
            mem_we = dp_lanes;
         end
         ST_RMW_WR: begin
            mem_en    = 1'b1;
            mem_we    = 4'b1111;
            mem_wdata = merged;
         end
         default: ;
      endcase
   end

   bbsram_mem #(
      .WORDS (WORDS),
      .LANES (4)
   ) u_mem (
      .clk     (clk),
      .en_i    (mem_en),
      .we_i    (mem_we),
      .addr_i  (dp_word),
      .wdata_i (mem_wdata),
      .rdata_o (mem_q)
   );

   always_comb begin
      if (state == ST_RD_DATA) hrdata = dp_alias ? {31'd0, mem_q[dp_bit]} : mem_q;
      else                     hrdata = '0;
   end

   // R6: every error response is a stalled cycle followed by a completing one
   a_r6_err_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && !hreadyout) |=> (hresp && hreadyout));

   // R7 / R8: no memory activity while an error is reported
   a_r7_err_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      hresp |-> !mem_en);

   // R10: the bit-window read is followed at once by the write-back to the same word
   a_r10_rmw_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we == 4'b0000 && state == ST_RMW_RD) |=>
      (mem_we == 4'b1111 && dp_word == $past(dp_word)));

   // R2 / R4: memory reads only happen in a stalled cycle (the single wait state)
   a_r2_read_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we == 4'b0000) |-> !hreadyout);

endmodule

// File: tb/sim_bbsram_ctrl.sv
`timescale 1ns/1ps
module sim_bbsram_ctrl;

   localparam int unsigned WIN = 256;
   localparam int unsigned FIT = 128;
   localparam int unsigned NW  = FIT / 4;
   localparam logic [31:0] DB  = 32'h2000_0000;
   localparam logic [31:0] AB  = 32'h2200_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsel = 1'b0;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hwrite = 1'b0;
   logic [2:0]  hsize = 3'd2;
   logic [31:0] hwdata = '0;
   logic [31:0] hrdata;
   logic        hreadyout;
   logic        hresp;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   logic [31:0] model [NW];

   always #2 clk = ~clk;

   bbsram_ctrl #(
      .WIN_BYTES   (WIN),
      .FIT_BYTES   (FIT),
      .DIRECT_BASE (DB),
      .ALIAS_BASE  (AB)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
      .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata),
      .hreadyout(hreadyout), .hresp(hresp)
   );

   function automatic logic [31:0] pat(input int i);
      return (32'h9E37_79B9 * (i + 1)) ^ 32'h0F0F_5A5A;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One complete transfer; returns data, final response, wait count and first-cycle response
   task automatic xfer(input logic [31:0] a, input bit wr, input logic [2:0] sz, input logic [31:0] wd,
                       output logic [31:0] rd, output logic rsp, output int waits, output logic rsp1);
      @(negedge clk);
      hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = wr; hsize = sz;
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00; hwdata = wd;
      waits = 0;
      rsp1 = hresp;
      while (!hreadyout) begin
         waits++;
         @(negedge clk);
      end
      rd = hrdata;
      rsp = hresp;
   endtask

   task automatic check_all_words(input string req);
      logic [31:0] rd; logic rsp; int w; logic r1;
      for (int i = 0; i < NW; i++) begin
         xfer(DB + 32'(4 * i), 1'b0, 3'd2, '0, rd, rsp, w, r1);
         chk(req, "word readback", rd, model[i]);
      end
   endtask

   task automatic expect_error(input string req, input logic [31:0] a, input bit wr);
      logic [31:0] rd; logic rsp; int w; logic r1;
      xfer(a, wr, 3'd2, 32'hDEAD_BEEF, rd, rsp, w, r1);
      chk(req, "first cycle hresp", {31'd0, r1}, 32'd1);
      chk(req, "stall count", w, 32'd1);
      chk(req, "final hresp", {31'd0, rsp}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] rd; logic rsp; int w; logic r1;
      logic nv;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1", "hreadyout after reset", {31'd0, hreadyout}, 32'd1);
      chk("R1", "hresp after reset", {31'd0, hresp}, 32'd0);

      // R2: word writes then reads
      for (int i = 0; i < NW; i++) begin
         model[i] = pat(i);
         xfer(DB + 32'(4 * i), 1'b1, 3'd2, model[i], rd, rsp, w, r1);
         chk("R2", "write waits", w, 32'd0);
         chk("R2", "write hresp", {31'd0, rsp}, 32'd0);
      end
      for (int i = 0; i < NW; i++) begin
         xfer(DB + 32'(4 * i), 1'b0, 3'd2, '0, rd, rsp, w, r1);
         chk("R2", "read data", rd, model[i]);
         chk("R2", "read waits", w, 32'd1);
      end

      // R3: byte writes on words 0..7, halfword writes on words 8..15
      for (int i = 0; i < 8; i++) begin
         for (int o = 0; o < 4; o++) begin
            logic [7:0] v;
            v = 8'(i * 16 + o + 1);
            xfer(DB + 32'(4 * i + o), 1'b1, 3'd0, {4{v}}, rd, rsp, w, r1);
            model[i][8*o +: 8] = v;
         end
      end
      for (int i = 8; i < 16; i++) begin
         for (int o = 0; o < 4; o += 2) begin
            logic [15:0] h;
            h = 16'(i * 257 + o + 3);
            xfer(DB + 32'(4 * i + o), 1'b1, 3'd1, {2{h}}, rd, rsp, w, r1);
            model[i][8*o +: 16] = h;
         end
      end
      // single byte on a fresh word to expose lane leakage
      xfer(DB + 32'(4 * 20 + 2), 1'b1, 3'd0, 32'hA5A5_A5A5, rd, rsp, w, r1);
      model[20][23:16] = 8'hA5;
      check_all_words("R3");

      // R4: read every bit through the bit window
      for (int i = 0; i < NW; i++) begin
         for (int b = 0; b < 32; b++) begin
            xfer(AB + 32'(i * 128 + b * 4), 1'b0, 3'd2, '0, rd, rsp, w, r1);
            chk("R4", "bit read", rd, {31'd0, model[i][b]});
            if (b == 0) chk("R4", "bit read waits", w, 32'd1);
         end
      end

      // R5: toggle every bit through the bit window with junk in hwdata[31:1]
      for (int i = 0; i < NW; i++) begin
         for (int b = 0; b < 32; b++) begin
            nv = ~model[i][b];
            xfer(AB + 32'(i * 128 + b * 4), 1'b1, 3'd2, {31'h2AAA_AAAA, nv}, rd, rsp, w, r1);
            model[i][b] = nv;
            if (b == 5) chk("R5", "bit write waits", w, 32'd1);
            if (b == 5) chk("R5", "bit write hresp", {31'd0, rsp}, 32'd0);
            if ((b % 8) == 7) begin
               xfer(DB + 32'(4 * i), 1'b0, 3'd2, '0, rd, rsp, w, r1);
               chk("R5", "word after bit writes", rd, model[i]);
            end
         end
      end

      // R6 / R7: direct window above the fitted size
      for (int a = FIT; a < WIN; a += 4) begin
         expect_error("R6", DB + 32'(a), 1'b0);
         expect_error("R6", DB + 32'(a), 1'b1);
      end
      check_all_words("R7");

      // R8: bit window above the fitted size
      for (int a = FIT; a < WIN; a += 4) begin
         expect_error("R8", AB + 32'(a * 32), 1'b1);
         expect_error("R8", AB + 32'(a * 32 + ((a / 4) % 32) * 4), 1'b0);
      end
      check_all_words("R8");

      // R9: outside both windows
      expect_error("R9", DB + 32'(WIN), 1'b0);
      expect_error("R9", DB - 32'd4, 1'b1);
      expect_error("R9", AB + 32'(WIN * 32), 1'b1);
      expect_error("R9", 32'h4000_0000, 1'b0);
      check_all_words("R9");

      // R10: direct read pipelined behind a bit write to the same word
      nv = ~model[3][9];
      @(negedge clk);
      hsel = 1'b1; htrans = 2'b10; haddr = AB + 32'(3 * 128 + 9 * 4); hwrite = 1'b1; hsize = 3'd2;
      @(negedge clk);
      hwdata = {31'd0, nv};
      haddr = DB + 32'd12; hwrite = 1'b0;
      chk("R10", "stall in read half", {31'd0, hreadyout}, 32'd0);
      @(negedge clk);
      chk("R10", "ready in write-back", {31'd0, hreadyout}, 32'd1);
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00;
      chk("R10", "following read stalls", {31'd0, hreadyout}, 32'd0);
      @(negedge clk);
      model[3][9] = nv;
      chk("R10", "following read ready", {31'd0, hreadyout}, 32'd1);
      chk("R10", "following read sees update", hrdata, model[3]);

      // R11: unselected or idle/busy cycles start nothing
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b10; hwrite = 1'b1; haddr = DB; hwdata = 32'h1234_5678;
      @(negedge clk);
      chk("R11", "hsel low ready", {31'd0, hreadyout}, 32'd1);
      chk("R11", "hsel low resp", {31'd0, hresp}, 32'd0);
      hsel = 1'b1; htrans = 2'b00;
      @(negedge clk);
      chk("R11", "idle ready", {31'd0, hreadyout}, 32'd1);
      htrans = 2'b01;
      @(negedge clk);
      chk("R11", "busy ready", {31'd0, hreadyout}, 32'd1);
      chk("R11", "busy resp", {31'd0, hresp}, 32'd0);
      hsel = 1'b0; htrans = 2'b00;
      xfer(DB, 1'b0, 3'd2, '0, rd, rsp, w, r1);
      chk("R11", "word 0 unchanged", rd, model[0]);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule